// File: doc/BRIEF.md
# Paged Management Register Bridge

This block is an APB3 slave that lets a processor reach a 21-bit space of 16-bit physical-coding-sublayer management registers. A target address is a 5-bit device number in bits [20:16] above a 16-bit register number in bits [15:0]. Behind the bridge sits a small behavioural register store with a plain synchronous port: address, write data, byte strobes and a registered read word.

One of two address maps is picked at elaboration. In the flat map, every target register has its own bus slot, so the bus register index is the full 21-bit target address. In the paged map, the bus aperture holds only 256 register slots. Slot 255 is a page register that holds target bits [20:8]. Slots 0 to 254 reach the current page, with the slot number as target bits [7:0]. A small aperture can therefore walk the whole space. The byte distance between registers on the bus is set by a parameter to 2 or 4, and the bus data width follows it.

Top module: `mgmt_window_bridge`

## Requirements
- R1: After reset the page register reads 0, and any target register that was never written reads 0.
- R2: In the paged map, a bus register index n in the range 0..254 reaches target address {page, n[7:0]}.
- R3: In the paged map, bus register index 255 is the page register. It is 13 bits wide and readable and writable. On a write, byte strobe 0 loads bits [7:0] and byte strobe 1 loads bits [12:8]. Read bits above 12 are 0.
- R4: A page register write takes effect for the very next transfer, with no added wait state. The page register changes only on such a write.
- R5: In the flat map, the bus register index is the full 21-bit target address, bits [20:16] being the device number.
- R6: The bus register index is the byte address shifted right by 1 (stride 2, 16-bit bus) or by 2 (stride 4, 32-bit bus). With stride 4, read bits [31:16] are always 0 and write bits [31:16] are ignored.
- R7: PSLVERR is raised in the access phase in three cases: a byte address not aligned to the stride, a flat-map index of 2^21 or more, or a paged-map index of 256 or more. Such a write changes nothing, and such a read returns 0.
- R8: On a write, byte strobe 0 updates register bits [7:0] and byte strobe 1 updates bits [15:8]. A write with both strobes clear changes nothing.
- R9: Every transfer completes in its first access cycle, with PREADY high.
- R10: Two target addresses that differ only in bits [20:8] hold independent values. They never alias.
- R11: The store keeps up to N_SLOTS distinct written addresses. A read of an unwritten address returns 0 and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | BUS_AW | APB byte address |
| pwdata | input | 8*STRIDE_BYTES | APB write data |
| pstrb | input | STRIDE_BYTES | APB byte strobes |
| prdata | output | 8*STRIDE_BYTES | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error response |

## Verification
The paged instance is driven in three ways:
- Writes to random pages and offsets, each issued right after a page change, then read back after the page has moved elsewhere. This separates a correct page-plus-offset join from a stale page or a dropped page.
- A sweep that flips each of the 13 page bits in turn against one shared base. Any bit lost from the target address shows up as aliasing.
- Partial and empty strobe patterns, plus misaligned and over-aperture addresses. These separate byte-lane handling from error gating.

A second instance, using the flat map with a 4-byte stride, takes random 21-bit targets with junk in the upper write half. This shows that the index shift is right, that the upper read half is zero, and that addresses above 21 bits are refused.

// File: rtl/mwb_pkg.sv
// Shared widths and types for the paged management register bridge.
package mwb_pkg;
    localparam int TGT_W = 21;   // full management target address
    localparam int VP_W  = 13;   // page register width, target bits [20:8]
    localparam int REG_W = 16;   // management register width
    localparam int WIN_W = 8;    // offset bits inside one page

    typedef logic [TGT_W-1:0] tgt_addr_t;
    typedef logic [VP_W-1:0]  page_t;
    typedef logic [REG_W-1:0] reg_word_t;

    // Result of decoding one bus address
    typedef struct packed {
        logic      err;     // misaligned or out of range
        logic      is_page; // hits the page register slot
        tgt_addr_t tgt;     // target register address
    } xlate_t;

    // Merge a 16-bit write into an old value under two byte strobes
    function automatic reg_word_t merge_bytes(reg_word_t old_v, reg_word_t new_v,
                                              logic [1:0] strb);
        reg_word_t r;
        r = old_v;
        if (strb[0]) r[7:0]  = new_v[7:0];
        if (strb[1]) r[15:8] = new_v[15:8];
        return r;
    endfunction
endpackage

// File: rtl/mwb_addr_xlate.sv
// Bus address decoder. Turns an APB byte address into a target register
// address, flags the page-register slot and flags bad addresses.
// Assumes STRIDE_BYTES is 2 or 4 and BUS_AW is at most 64.
// Purely combinational; the chosen map is fixed by INDIRECT.
module mwb_addr_xlate
    import mwb_pkg::*;
#(
    parameter int INDIRECT     = 1,
    parameter int STRIDE_BYTES = 2,
    parameter int BUS_AW       = 10
) (
    input  logic [BUS_AW-1:0] paddr,
    input  page_t             page,
    output xlate_t            xo
);
    localparam int SH = (STRIDE_BYTES == 4) ? 2 : 1;

    logic [63:0] idx64;
    logic        misalign;

    // Register index and alignment check
    always_comb begin
        idx64    = 64'(paddr) >> SH;
        misalign = |paddr[SH-1:0];
    end

    generate
        if (INDIRECT != 0) begin : g_paged
            // Paged map: page register supplies the upper target bits
            always_comb begin
                xo.tgt     = {page, idx64[WIN_W-1:0]};
                xo.is_page = (idx64[WIN_W-1:0] == 8'hFF);
                xo.err     = misalign | (|idx64[63:WIN_W]);
            end
        end else begin : g_flat
            logic unused_page;
            // Flat map: index is the whole target address
            always_comb begin
                unused_page = ^page;
                xo.tgt      = idx64[TGT_W-1:0];
                xo.is_page  = 1'b0;
                xo.err      = misalign | (|idx64[63:TGT_W]);
            end
        end
    endgenerate
endmodule

// File: rtl/mwb_page_reg.sv
// Page (viewport) register for the paged map. Holds target bits [20:8].
// Assumes the caller only raises we for an error-free write to its slot.
module mwb_page_reg
    import mwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  page_t wmask,
    input  page_t wdata,
    output page_t page
);
    // Masked update of the page value
    always_ff @(posedge clk) begin
        if (!rst_n) page <= '0;
        else if (we) page <= (page & ~wmask) | (wdata & wmask);
    end

    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(page));
endmodule

// File: rtl/mwb_regstore.sv
// Behavioural management register store. A small associative array of
// tagged 16-bit words stands in for the 2M-entry target space.
// Writes hit an existing tag or claim the lowest free slot; a write to a
// new address when all slots are taken is dropped. Reads of an unknown
// address give 0. Read data is registered (one cycle after re).
// Assumes we and re are never raised in the same cycle.
module mwb_regstore
    import mwb_pkg::*;
#(
    parameter int N_SLOTS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  tgt_addr_t  waddr,
    input  reg_word_t  wdata,
    input  logic [1:0] wstrb,
    input  logic       re,
    input  tgt_addr_t  raddr,
    output reg_word_t  rdata
);
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    logic [N_SLOTS-1:0] valid;
    tgt_addr_t          tag  [N_SLOTS];
    reg_word_t          data [N_SLOTS];

    logic [N_SLOTS-1:0] whit;
    logic               whit_any;
    logic [SLOT_W-1:0]  whit_idx;
    logic               free_any;
    logic [SLOT_W-1:0]  free_idx;
    reg_word_t          rd_comb;

    // Tag match for the write port
    always_comb begin
        whit     = '0;
        whit_idx = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (valid[i] && tag[i] == waddr) begin
                whit[i]  = 1'b1;
                whit_idx = SLOT_W'(i);
            end
        end
        whit_any = |whit;
    end

    // Lowest free slot
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N_SLOTS-1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    // Tag match for the read port
    always_comb begin
        rd_comb = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (valid[i] && tag[i] == raddr) rd_comb = data[i];
        end
    end

    // Slot occupancy and registered read word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            rdata <= '0;
        end else begin
            if (we && |wstrb && !whit_any && free_any) valid[free_idx] <= 1'b1;
            if (re) rdata <= rd_comb;
        end
    end

    // Tag and data contents (no reset needed, qualified by valid)
    always_ff @(posedge clk) begin
        if (we && |wstrb) begin
            if (whit_any) begin
                data[whit_idx] <= merge_bytes(data[whit_idx], wdata, wstrb);
            end else if (free_any) begin
                tag[free_idx]  <= waddr;
                data[free_idx] <= merge_bytes('0, wdata, wstrb);
            end
        end
    end

    p_tag_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(whit));
    p_alloc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $countones(valid) == $countones($past(valid)));
    p_ports_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));
endmodule

// File: rtl/mgmt_window_bridge.sv
// APB3 slave into a 21-bit space of 16-bit management registers.
// Setup phase: decode the address and launch the store read.
// Access phase: respond with PREADY high, commit writes.
// Assumes an APB-compliant master (address and controls stable from setup
// through access). STRIDE_BYTES must be 2 or 4; the data bus is 8*STRIDE_BYTES.
module mgmt_window_bridge
    import mwb_pkg::*;
#(
    parameter int INDIRECT     = 1,
    parameter int STRIDE_BYTES = 2,
    parameter int BUS_AW       = 10,
    parameter int N_SLOTS      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [BUS_AW-1:0]         paddr,
    input  logic [8*STRIDE_BYTES-1:0] pwdata,
    input  logic [STRIDE_BYTES-1:0]   pstrb,
    output logic [8*STRIDE_BYTES-1:0] prdata,
    output logic                      pready,
    output logic                      pslverr
);
    localparam int DW = 8 * STRIDE_BYTES;

    page_t     page;
    xlate_t    xo;
    logic      setup_ph, access_ph;
    logic      st_we, st_re, pg_we;
    reg_word_t st_rdata;
    logic      err_q, pg_q, rd_q;
    reg_word_t rd_word;

    mwb_addr_xlate #(
        .INDIRECT(INDIRECT), .STRIDE_BYTES(STRIDE_BYTES), .BUS_AW(BUS_AW)
    ) u_xlate (
        .paddr(paddr), .page(page), .xo(xo)
    );

    // Phase decode and store / page controls
    always_comb begin
        setup_ph  = psel & ~penable;
        access_ph = psel & penable;
        st_re = setup_ph & ~pwrite & ~xo.err & ~xo.is_page;
        st_we = access_ph & pwrite & ~xo.err & ~xo.is_page & (|pstrb[1:0]);
        pg_we = access_ph & pwrite & ~xo.err & xo.is_page & (|pstrb[1:0]);
    end

    generate
        if (INDIRECT != 0) begin : g_page
            mwb_page_reg u_page (
                .clk(clk), .rst_n(rst_n), .we(pg_we),
                .wmask({{(VP_W-8){pstrb[1]}}, {8{pstrb[0]}}}),
                .wdata(pwdata[VP_W-1:0]),
                .page(page)
            );
            p_win_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
                st_we |-> (xo.tgt[TGT_W-1:WIN_W] == page));
        end else begin : g_nopage
            logic unused_pgwe;
            assign page = '0;
            assign unused_pgwe = pg_we;
        end
    endgenerate

    mwb_regstore #(.N_SLOTS(N_SLOTS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(st_we), .waddr(xo.tgt), .wdata(pwdata[REG_W-1:0]), .wstrb(pstrb[1:0]),
        .re(st_re), .raddr(xo.tgt), .rdata(st_rdata)
    );

    // Capture the response kind in the setup phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            pg_q  <= 1'b0;
            rd_q  <= 1'b0;
        end else if (setup_ph) begin
            err_q <= xo.err;
            pg_q  <= xo.is_page;
            rd_q  <= ~pwrite;
        end
    end

    // Read word selection and APB response
    always_comb begin
        rd_word = pg_q ? REG_W'(page) : st_rdata;
        prdata  = (access_ph && rd_q && !err_q) ? DW'(rd_word) : '0;
        pready  = 1'b1;
        pslverr = access_ph & err_q;
    end

    generate
        if (STRIDE_BYTES == 4) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^{pwdata[DW-1:REG_W], pstrb[STRIDE_BYTES-1:2]};
            p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                access_ph |-> (prdata[DW-1:REG_W] == '0));
        end
    endgenerate

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ph && pslverr) |-> (prdata == '0 && !st_we && !pg_we));
    p_no_write_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ph && pwrite) |-> (prdata == '0));
endmodule

// File: tb/sim_mgmt_window_bridge.sv
module sim_mgmt_window_bridge;
    logic clk = 0;
    logic rst_n = 0;
    always #4 clk = ~clk;

    // u0: paged map, stride 2
    logic        a_psel = 0, a_pen = 0, a_pwr = 0;
    logic [9:0]  a_addr = 0;
    logic [15:0] a_wd = 0, a_rd;
    logic [1:0]  a_st = 0;
    logic        a_rdy, a_err;
    // u1: flat map, stride 4
    logic        b_psel = 0, b_pen = 0, b_pwr = 0;
    logic [23:0] b_addr = 0;
    logic [31:0] b_wd = 0, b_rd;
    logic [3:0]  b_st = 0;
    logic        b_rdy, b_err;

    mgmt_window_bridge #(.INDIRECT(1), .STRIDE_BYTES(2), .BUS_AW(10), .N_SLOTS(32)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(a_psel), .penable(a_pen), .pwrite(a_pwr),
        .paddr(a_addr), .pwdata(a_wd), .pstrb(a_st), .prdata(a_rd),
        .pready(a_rdy), .pslverr(a_err));
    mgmt_window_bridge #(.INDIRECT(0), .STRIDE_BYTES(4), .BUS_AW(24), .N_SLOTS(32)) u1 (
        .clk(clk), .rst_n(rst_n), .psel(b_psel), .penable(b_pen), .pwrite(b_pwr),
        .paddr(b_addr), .pwdata(b_wd), .pstrb(b_st), .prdata(b_rd),
        .pready(b_rdy), .pslverr(b_err));

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    // Reference model state
    logic [15:0] mem0 [int];
    logic [15:0] mem1 [int];
    int          page0 = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mrg(logic [15:0] o, logic [15:0] n, logic [1:0] s);
        logic [15:0] r = o;
        if (s[0]) r[7:0] = n[7:0];
        if (s[1]) r[15:8] = n[15:8];
        return r;
    endfunction

    // One transfer on the paged instance, checked against the model
    task automatic op0(bit wr, int addr, logic [15:0] wd, logic [1:0] st, string req);
        int idx = addr >> 1;
        bit e = (addr % 2 != 0) || (idx >= 256);
        int key = (page0 << 8) | (idx & 255);
        logic [15:0] exp_rd;
        logic [15:0] rd;
        logic er, rdy;
        exp_rd = 16'h0;
        if (!wr && !e) exp_rd = (idx == 255) ? 16'(page0) : (mem0.exists(key) ? mem0[key] : 16'h0);
        @(negedge clk);
        a_psel = 1; a_pen = 0; a_pwr = wr; a_addr = 10'(addr); a_wd = wd; a_st = st;
        @(negedge clk);
        a_pen = 1;
        #1; rd = a_rd; er = a_err; rdy = a_rdy;
        @(posedge clk); #1;
        a_psel = 0; a_pen = 0;
        chk("R9 ready", 32'(rdy), 32'd1);
        chk({req, " err"}, 32'(er), 32'(e));
        if (!wr) chk({req, " rdata"}, 32'(rd), 32'(exp_rd));
        if (wr && !e && st != 0) begin
            if (idx == 255) page0 = int'(mrg(16'(page0), wd, st) & 16'h1FFF);
            else mem0[key] = mrg(mem0.exists(key) ? mem0[key] : 16'h0, wd, st);
        end
    endtask

    // One transfer on the flat instance, checked against the model
    task automatic op1(bit wr, logic [23:0] addr, logic [31:0] wd, logic [3:0] st, string req);
        int idx = int'(addr >> 2);
        bit e = (addr[1:0] != 0) || (idx >= (1 << 21));
        logic [31:0] exp_rd;
        logic [31:0] rd;
        logic er, rdy;
        exp_rd = 32'h0;
        if (!wr && !e && mem1.exists(idx)) exp_rd = 32'(mem1[idx]);
        @(negedge clk);
        b_psel = 1; b_pen = 0; b_pwr = wr; b_addr = addr; b_wd = wd; b_st = st;
        @(negedge clk);
        b_pen = 1;
        #1; rd = b_rd; er = b_err; rdy = b_rdy;
        @(posedge clk); #1;
        b_psel = 0; b_pen = 0;
        chk("R9 ready", 32'(rdy), 32'd1);
        chk({req, " err"}, 32'(er), 32'(e));
        if (!wr) chk({req, " rdata"}, rd, exp_rd);
        if (wr && !e && st[1:0] != 0)
            mem1[idx] = mrg(mem1.exists(idx) ? mem1[idx] : 16'h0, wd[15:0], st[1:0]);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int offs [8];
        int pgs [8];
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        op0(0, 10'h1FE, 0, 0, "R1 page reset");
        op0(0, 10'h020, 0, 0, "R1 unwritten");
        op1(0, 24'h000040, 0, 0, "R1 flat unwritten");

        // R3: page register read/write and width
        op0(1, 10'h1FE, 16'hFFFF, 2'b11, "R3 page write");
        op0(0, 10'h1FE, 0, 0, "R3 page width");
        op0(1, 10'h1FE, 16'h0ABC, 2'b01, "R3 page low byte");
        op0(0, 10'h1FE, 0, 0, "R3 page merge");

        // R2 R4: write right after each page change, read back later
        for (int i = 0; i < 8; i++) begin
            pgs[i]  = int'($urandom_range(0, 8191));
            offs[i] = int'($urandom_range(0, 254));
            op0(1, 10'h1FE, 16'(pgs[i]), 2'b11, "R4 page set");
            op0(1, offs[i] * 2, 16'($urandom), 2'b11, "R4 next write");
        end
        for (int i = 0; i < 8; i++) begin
            op0(1, 10'h1FE, 16'(pgs[i]), 2'b11, "R2 page set");
            op0(0, offs[i] * 2, 0, 0, "R2 readback");
        end

        // R10: flip each page bit against one base
        op0(1, 10'h1FE, 16'h00A5, 2'b11, "R10 base page");
        op0(1, 10'h066, 16'h5A5A, 2'b11, "R10 base write");
        for (int b = 0; b < 13; b++) begin
            op0(1, 10'h1FE, 16'(13'h00A5 ^ (13'd1 << b)), 2'b11, "R10 page");
            op0(1, 10'h066, 16'(16'h1000 + b), 2'b11, "R10 write");
        end
        op0(1, 10'h1FE, 16'h00A5, 2'b11, "R10 base page");
        op0(0, 10'h066, 0, 0, "R10 base intact");
        for (int b = 0; b < 13; b++) begin
            op0(1, 10'h1FE, 16'(13'h00A5 ^ (13'd1 << b)), 2'b11, "R10 page");
            op0(0, 10'h066, 0, 0, "R10 no alias");
        end

        // R8: byte strobes
        op0(1, 10'h1FE, 16'h0003, 2'b11, "R8 page");
        op0(1, 10'h010, 16'h1234, 2'b11, "R8 full");
        op0(1, 10'h010, 16'hAB55, 2'b01, "R8 low lane");
        op0(0, 10'h010, 0, 0, "R8 low lane");
        op0(1, 10'h010, 16'h9900, 2'b10, "R8 high lane");
        op0(0, 10'h010, 0, 0, "R8 high lane");
        op0(1, 10'h010, 16'hFFFF, 2'b00, "R8 empty strobe");
        op0(0, 10'h010, 0, 0, "R8 empty strobe");

        // R7: errors on the paged instance
        op0(0, 10'h011, 0, 0, "R7 misaligned read");
        op0(1, 10'h011, 16'h7777, 2'b11, "R7 misaligned write");
        op0(0, 10'h010, 0, 0, "R7 unchanged");
        op0(0, 10'h200, 0, 0, "R7 over aperture");
        op0(1, 10'h3FE, 16'h0001, 2'b11, "R7 over aperture write");
        op0(0, 10'h1FE, 0, 0, "R7 page unchanged");

        // R5 R6: flat map, stride 4, junk in upper write half
        for (int i = 0; i < 8; i++) begin
            logic [20:0] t = 21'($urandom);
            op1(1, {1'b0, t, 2'b00}, $urandom, 4'hF, "R5 write");
            op1(0, {1'b0, t, 2'b00}, 0, 0, "R6 readback");
        end
        // R10 in the flat map
        op1(1, {1'b0, 21'h0A5033, 2'b00}, 32'hFFFF_2222, 4'hF, "R10 flat base");
        for (int b = 8; b < 21; b++)
            op1(1, {1'b0, 21'h0A5033 ^ (21'd1 << b), 2'b00}, 32'(b), 4'hF, "R10 flat");
        op1(0, {1'b0, 21'h0A5033, 2'b00}, 0, 0, "R10 flat base");
        for (int b = 8; b < 21; b++)
            op1(0, {1'b0, 21'h0A5033 ^ (21'd1 << b), 2'b00}, 0, 0, "R10 flat");
        // R7 in the flat map
        op1(0, 24'h800000, 0, 0, "R7 beyond 21 bits");
        op1(1, 24'h800000, 32'h1, 4'hF, "R7 beyond write");
        op1(0, 24'h000000, 0, 0, "R7 no wrap");
        op1(0, 24'h000006, 0, 0, "R7 flat misaligned");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule